// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block connects a simple request port to an asynchronous-style DRAM whose row and column addresses share one set of address pins. A request carries a read/write flag, a row, a column and write data, and is held valid by the requester until the controller answers with a one-cycle acknowledge. The controller opens a row by driving the row address and pulling the active-low row strobe. It then drives the column address and pulses the active-low column strobe. For reads, it captures the data bus at the end of the column pulse.

The row strobe stays low after an access completes, so the row remains open. A later request to the same row costs only a column pulse. A request to a different row first raises the row strobe for a precharge interval and then opens the new row. If no request arrives for a set number of cycles, the row is closed. Every strobe interval is a parameter counted in clock cycles. The DRAM data bus is split into separate output, output-enable and input signals so that a pad ring can join them.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and after it is released, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `req_ack` is low and no row is open. The first request therefore opens its row without a precharge interval and is acknowledged T_RCD+T_CAS+1 sampling cycles after it is presented.
- R2: When a row is opened, `dram_addr` carries the row (in its low ROW_W bits) as `dram_ras_n` falls. `dram_cas_n` falls exactly T_RCD cycles after `dram_ras_n`.
- R3: Each column access holds `dram_cas_n` low for exactly T_CAS cycles, with the column on `dram_addr` as it falls. Between two column pulses inside one open row, `dram_cas_n` stays high for at least T_CP cycles.
- R4: A request to the open row causes no new fall of `dram_ras_n`. When it is presented in the acknowledge cycle of the previous access, it is acknowledged T_CP+T_CAS+1 cycles later.
- R5: A request to a row other than the open one raises `dram_ras_n` for exactly T_RP cycles, then opens the new row. When it is presented in the previous acknowledge cycle, it is acknowledged T_CP+T_RP+T_RCD+T_CAS+1 cycles later.
- R6: For a read, `rsp_rdata` holds the value on `dram_dq_in` at the last cycle of the column pulse. It is valid in the cycle `req_ack` is high, and `req_ack` is high for exactly one cycle per request.
- R7: A write drives `dram_we_n` low and `dram_dq_oe` high with `req_wdata` on `dram_dq_out`, only while `dram_cas_n` is low. A read never drives `dram_we_n` low.
- R8: After the last access, if no request arrives, `dram_ras_n` rises T_CP+IDLE_CLOSE cycles after the acknowledge cycle. The next request then opens its row as from reset.
- R9: `dram_cas_n` is never low while `dram_ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row part of the address |
| req_col | input | COL_W | Column part of the address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `req_ack` |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench sweeps every cell of a small array three times:
- row-major writes, which mix row changes with hits;
- column-major reads, where every access changes row;
- row-major reads after an idle close.

For each access it checks the exact acknowledge latency and the number of row-strobe falls. A controller that reopened the row on every hit, or skipped precharge on a row change, would show an extra or missing fall and the wrong latency. A bus monitor inside the bench measures every column-pulse width, the row-to-column delay and the precharge length. This catches a counter that is off by one. It also checks that data read back matches what was written, which catches a column latched from the wrong address or data sampled before the pulse ends. The idle-close window is checked one cycle before and one cycle at the expected edge, so a close that comes one cycle early or late is reported.

// File: rtl/fpm_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes nothing beyond the controller's own state set.
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // no row open, strobes high
        ST_RCD,    // row strobe low, waiting row-to-column delay
        ST_CAS,    // column strobe low
        ST_CP,     // column strobe high after a pulse
        ST_OPEN,   // row open, waiting for a request
        ST_PRE     // row strobe high, precharging
    } fpm_state_t;
endpackage

// File: rtl/fpm_down_counter.sv
// Loadable down counter that stops at zero; used to time strobe phases.
// Assumes load has priority over counting.
module fpm_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a new interval or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fpm_row_tracker.sv
// Remembers which row is open and compares incoming rows against it.
// Assumes set and clear are never asserted together.
module fpm_row_tracker #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_open,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clear,
    input  logic [ROW_W-1:0] probe_row,
    output logic             row_open,
    output logic             row_hit
);
    logic [ROW_W-1:0] open_row_q;

    // Track the open row and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open   <= 1'b0;
            open_row_q <= '0;
        end else if (set_open) begin
            row_open   <= 1'b1;
            open_row_q <= set_row;
        end else if (clear) begin
            row_open   <= 1'b0;
        end
    end

    assign row_hit = row_open && (probe_row == open_row_q);

    // R1: no row is considered open right after reset.
    a_r1_no_row_after_reset: assert property (@(posedge clk)
        !rst_n |=> !row_open);
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode DRAM controller: keeps a row open and issues only column
// pulses for hits. Precharges on a row change and closes the row after an
// idle window. Assumes the requester holds req_valid and its fields stable
// until req_ack, and that every timing parameter is at least 1.
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W      = 8,
    parameter int COL_W      = 8,
    parameter int DATA_W     = 16,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 3,
    parameter int T_CAS      = 2,
    parameter int T_CP       = 2,
    parameter int IDLE_CLOSE = 64,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int TMAX   = (T_RP > T_RCD ? T_RP : T_RCD) > (T_CAS > T_CP ? T_CAS : T_CP)
                          ? (T_RP > T_RCD ? T_RP : T_RCD) : (T_CAS > T_CP ? T_CAS : T_CP);
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int IDLE_W = $clog2(IDLE_CLOSE + 1);

    fpm_state_t        state_q, state_d;
    logic [CNT_W-1:0]  ph_load_val;
    logic              ph_zero, idle_zero;
    logic              row_open, row_hit;
    logic              accept, pend_q, wr_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;

    // Phase timer for precharge, row-to-column, column pulse and gap.
    fpm_down_counter #(.W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .load(state_d != state_q), .load_val(ph_load_val), .zero(ph_zero)
    );

    // Idle timer: reloaded outside the open state, counts while open.
    fpm_down_counter #(.W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .load(state_q != ST_OPEN), .load_val(IDLE_W'(IDLE_CLOSE - 1)), .zero(idle_zero)
    );

    // Open-row register and hit compare against the incoming row.
    fpm_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .set_open(state_q == ST_RCD && ph_zero), .set_row(row_q),
        .clear(state_q == ST_OPEN && state_d == ST_PRE),
        .probe_row(req_row), .row_open(row_open), .row_hit(row_hit)
    );

    assign accept = req_valid && (state_q == ST_IDLE || state_q == ST_OPEN);

    // Next-state decision and the interval loaded on each state entry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RCD;
            ST_OPEN: begin
                if (req_valid)      state_d = row_hit ? ST_CAS : ST_PRE;
                else if (idle_zero) state_d = ST_PRE;
            end
            ST_PRE:  if (ph_zero) state_d = pend_q ? ST_RCD : ST_IDLE;
            ST_RCD:  if (ph_zero) state_d = ST_CAS;
            ST_CAS:  if (ph_zero) state_d = ST_CP;
            ST_CP:   if (ph_zero) state_d = ST_OPEN;
            default: state_d = ST_IDLE;
        endcase
        unique case (state_d)
            ST_PRE:  ph_load_val = CNT_W'(T_RP - 1);
            ST_RCD:  ph_load_val = CNT_W'(T_RCD - 1);
            ST_CAS:  ph_load_val = CNT_W'(T_CAS - 1);
            ST_CP:   ph_load_val = CNT_W'(T_CP - 1);
            default: ph_load_val = '0;
        endcase
    end

    // State register, request capture, read data capture and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_q    <= 1'b0;
            wr_q      <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            wdata_q   <= '0;
            rsp_rdata <= '0;
            req_ack   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_ack <= (state_q == ST_CAS) && ph_zero;
            if (accept) begin
                pend_q  <= 1'b1;
                wr_q    <= req_write;
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= req_wdata;
            end else if (state_q == ST_CAS) begin
                pend_q  <= 1'b0;
            end
            if (state_q == ST_CAS && ph_zero && !wr_q) rsp_rdata <= dram_dq_in;
        end
    end

    // DRAM pins are decoded from registered state only.
    assign dram_ras_n  = !(state_q == ST_RCD || state_q == ST_CAS ||
                           state_q == ST_CP  || state_q == ST_OPEN);
    assign dram_cas_n  = (state_q != ST_CAS);
    assign dram_addr   = (state_q == ST_CAS || state_q == ST_CP) ? ADDR_W'(col_q) : ADDR_W'(row_q);
    assign dram_we_n   = !(state_q == ST_CAS && wr_q);
    assign dram_dq_oe  = (state_q == ST_CAS) && wr_q;
    assign dram_dq_out = wdata_q;

    // Checker state: length of the current column pulse.
    logic [7:0] cas_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || dram_cas_n) cas_run_q <= '0;
        else if (cas_run_q != 8'hFF) cas_run_q <= cas_run_q + 1'b1;
    end

    a_r1_reset_strobes: assert property (@(posedge clk)
        !rst_n |=> (dram_ras_n && dram_cas_n && dram_we_n && !req_ack));
    a_r9_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    a_r7_we_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (!dram_cas_n && dram_dq_oe));
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    a_r3_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> (cas_run_q == 8'(T_CAS)));
    a_r4_open_has_row: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> row_open);
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
    localparam int RW = 2, CW = 3, DW = 8, AW = 3;
    localparam int TRP = 3, TRCD = 2, TCAS = 2, TCP = 1, TIDLE = 5;
    localparam int L_CLOSED = TRCD + TCAS + 1;
    localparam int L_HIT    = TCP + TCAS + 1;
    localparam int L_MISS   = TCP + TRP + TRCD + TCAS + 1;
    localparam int ROWS = 1 << RW, COLS = 1 << CW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ack, ras_n, cas_n, we_n, dq_oe;
    logic [DW-1:0] rsp_rdata, dq_out, dq_in;
    logic [AW-1:0] addr;

    int checks = 0, errors = 0, ras_falls = 0;
    logic [DW-1:0] mem [ROWS*COLS];
    logic [DW-1:0] expm [ROWS*COLS];
    logic [RW-1:0] lrow = '0;
    logic [CW-1:0] lcol = '0;

    always #2 clk = ~clk;

    fpm_dram_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RP(TRP), .T_RCD(TRCD),
                    .T_CAS(TCAS), .T_CP(TCP), .IDLE_CLOSE(TIDLE)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .dram_addr(addr),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    assign dq_in = mem[{lrow, lcol}];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // DRAM model and strobe monitor, sampled mid-cycle.
    logic prev_ras = 1'b1, prev_cas = 1'b1, first_cas = 1'b0;
    int since_ras = 0, cas_run = 0, cas_gap = 0, ras_high = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                chk(ras_high >= TRP, "R5 precharge length", ras_high, TRP);
                lrow = addr[RW-1:0];
                ras_falls++;
                since_ras = 0;
                first_cas = 1'b1;
            end else if (!ras_n) since_ras++;
            if (prev_cas && !cas_n) begin
                chk(!ras_n, "R9 cas under ras", ras_n, 0);
                if (first_cas) chk(since_ras == TRCD, "R2 row-to-column delay", since_ras, TRCD);
                else chk(cas_gap >= TCP, "R3 column gap", cas_gap, TCP);
                first_cas = 1'b0;
                lcol = addr[CW-1:0];
                if (!we_n) begin
                    chk(dq_oe, "R7 output enable with write", dq_oe, 1);
                    mem[{lrow, lcol}] = dq_out;
                end
                cas_run = 0;
            end
            if (!prev_cas && cas_n) chk(cas_run == TCAS, "R3 column pulse width", cas_run, TCAS);
            if (!we_n) chk(!cas_n, "R7 write strobe inside column pulse", cas_n, 0);
            if (!cas_n) cas_run++;
            cas_gap  = cas_n ? cas_gap + 1 : 0;
            ras_high = ras_n ? ras_high + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    function automatic logic [DW-1:0] pat(input int r, input int c, input int salt);
        return DW'((r * 37 + c * 11 + salt * 5 + 3) & 255);
    endfunction

    // One access: present it, wait for ack, check latency, data and row-strobe falls.
    task automatic access(input bit wr, input int r, input int c, input logic [DW-1:0] wd,
                          input int exp_lat, input int exp_falls, input string tag);
        int f0 = ras_falls;
        int k = 0;
        req_valid = 1'b1; req_write = wr;
        req_row = RW'(r); req_col = CW'(c); req_wdata = wd;
        if (wr) expm[r * COLS + c] = wd;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) chk(!req_ack, {tag, " R6 ack single cycle"}, req_ack, 0);
        end while (!req_ack && k < 100);
        chk(k == exp_lat, {tag, " latency"}, k, exp_lat);
        chk(ras_falls - f0 == exp_falls, {tag, " row strobe falls"}, ras_falls - f0, exp_falls);
        if (!wr) chk(rsp_rdata == expm[r * COLS + c], {tag, " R6 read data"},
                     rsp_rdata, expm[r * COLS + c]);
    endtask

    // Drop the request and check the idle close edge.
    task automatic idle_close(input string tag);
        req_valid = 1'b0;
        for (int k = 1; k <= TCP + TIDLE; k++) begin
            @(negedge clk);
            if (k == TCP + TIDLE - 1) chk(!ras_n, {tag, " R8 row still open"}, ras_n, 0);
            if (k == TCP + TIDLE)     chk(ras_n, {tag, " R8 row closed"}, ras_n, 1);
        end
        repeat (TRP + 2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < ROWS * COLS; i++) begin mem[i] = '0; expm[i] = '0; end
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!req_ack && rsp_rdata == '0, "R1 ack and data clear in reset", req_ack, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes high after reset", {ras_n, cas_n, we_n}, 7);
        // Row-major writes: R1 first open, R4 hits, R5 row changes, R7 writes.
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                access(1'b1, r, c, pat(r, c, 0),
                       (r == 0 && c == 0) ? L_CLOSED : (c == 0 ? L_MISS : L_HIT),
                       (c == 0) ? 1 : 0,
                       (r == 0 && c == 0) ? "R1 first write" : (c == 0 ? "R5 write miss" : "R4 write hit"));
        idle_close("after writes");
        // Column-major reads: every access changes row (R5, R6).
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                access(1'b0, r, c, '0, (r == 0 && c == 0) ? L_CLOSED : L_MISS, 1,
                       (r == 0 && c == 0) ? "R8 reopen read" : "R5 read miss");
        idle_close("after column reads");
        // Row-major reads: mostly hits (R4, R6).
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                access(1'b0, r, c, '0,
                       (r == 0 && c == 0) ? L_CLOSED : (c == 0 ? L_MISS : L_HIT),
                       (c == 0) ? 1 : 0, (c == 0) ? "R5 read miss" : "R4 read hit");
        // Overwrite then read back within the open row.
        access(1'b1, 2, 5, 8'hA5, L_MISS, 1, "R7 overwrite");
        access(1'b0, 2, 5, '0, L_HIT, 0, "R4 read after write");
        idle_close("final");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule